// File: doc/BRIEF.md
# Vector Mask Instruction Decoder

This block takes a 32-bit instruction word and works out whether it is one of the fifteen vector mask-manipulation instructions. There are three groups. The bitwise mask-combining group has eight operations. The scalar-result group holds population count and find-first. The mask-unary group holds set-before-first, set-only-first, set-including-first, iota and element index. For each word the block reports a legality flag and a compact operation code. It also passes on the destination index, a flag telling whether that destination is a scalar register, the two source indices and the mask-enable bit.

The decode logic is purely combinational. A single registered stage with a valid/ready handshake sits after it, so the block can be placed in a pipeline between fetch and issue. Every accepted word produces exactly one output beat, and an illegal word comes out as a beat with the legality flag cleared. Operand reads and execution happen elsewhere.

Top module: `vmask_decoder`

## Requirements
- R1: A word can be legal only when its bits [6:0] equal 7'b1010111 and its bits [14:12] equal 3'b010. Any other value in either field gives `out_legal`=0.
- R2: The output fields are taken from fixed bit positions: `out_dst` from bits [11:7], `out_src1` from [19:15], `out_src2` from [24:20] and `out_vm` from bit 25. The group selector is bits [31:26].
- R3: Selector values 6'b011000 through 6'b011111 are the eight bitwise mask ops, with operation codes 1 through 8 in that order (and-not, and, or, xor, or-not, nand, nor, xnor). They are legal only when bit 25 is 1.
- R4: Selector 6'b010000 is the scalar-result group. Bits [19:15] equal to 5'b10000 give population count (code 9), and 5'b10001 gives find-first (code 10). For these two, `out_scalar_dst` is 1. It is 0 for every other output.
- R5: Selector 6'b010100 is the mask-unary group, chosen by bits [19:15]. 5'b00001 gives set-before-first (code 11), 5'b00010 gives set-only-first (12), 5'b00011 gives set-including-first (13), 5'b10000 gives iota (14) and 5'b10001 gives element index (15).
- R6: Element index is legal only when bits [24:20] are all zero.
- R7: Any other selector value, and any other sub-code inside the scalar-result or mask-unary groups, is illegal.
- R8: When `out_legal` is 0, `out_op` is 0 (no operation) and `out_scalar_dst` is 0.
- R9: `in_ready` is high exactly when the output stage is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, every output holds its value.
- R10: A word accepted on a clock edge (`in_valid` and `in_ready` both high) appears at the outputs with `out_valid`=1 right after that edge. If no word is accepted and `out_ready` is high, `out_valid` drops. Reset clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Stage can take a word this cycle |
| in_word | input | 32 | Instruction word |
| out_valid | output | 1 | Decoded beat present |
| out_ready | input | 1 | Downstream takes the beat |
| out_legal | output | 1 | Word is a supported, well-formed mask instruction |
| out_op | output | 4 | Operation code, 0 when illegal |
| out_scalar_dst | output | 1 | Destination names a scalar register |
| out_dst | output | 5 | Destination index, bits [11:7] |
| out_src2 | output | 5 | Second source index, bits [24:20] |
| out_src1 | output | 5 | First source / sub-code, bits [19:15] |
| out_vm | output | 1 | Mask-enable bit, bit 25 |

## Verification
The checker properties assume that `in_valid`, `in_word` and `out_ready` are known after reset. They also assume that the downstream side may stall for any number of cycles, and that no particular word pattern is excluded. The bench drives all inputs on the falling clock edge, so those values stay known and steady across each rising edge. It holds `out_ready` low over several cycles while a new word is waiting, so the hold and backpressure properties are actually exercised. The decode patterns it sends cover every legal code and the neighbouring illegal ones in each group.

// File: rtl/vmdec_pkg.sv
package vmdec_pkg;
  localparam int ILEN  = 32;
  localparam int IDX_W = 5;
  localparam int OP_W  = 4;

  localparam logic [6:0] MAJOR_VEC  = 7'b1010111;
  localparam logic [2:0] F3_MASKVV  = 3'b010;
  localparam logic [5:0] SEL_SCALAR = 6'b010000;
  localparam logic [5:0] SEL_UNARY  = 6'b010100;
  localparam logic [2:0] SEL_LOGIC_HI = 3'b011;

  typedef enum logic [OP_W-1:0] {
    MOP_NONE     = 4'd0,
    MOP_ANDN     = 4'd1,
    MOP_AND      = 4'd2,
    MOP_OR       = 4'd3,
    MOP_XOR      = 4'd4,
    MOP_ORN      = 4'd5,
    MOP_NAND     = 4'd6,
    MOP_NOR      = 4'd7,
    MOP_XNOR     = 4'd8,
    MOP_POPCNT   = 4'd9,
    MOP_FIRST    = 4'd10,
    MOP_SETBEF   = 4'd11,
    MOP_SETONLY  = 4'd12,
    MOP_SETINCL  = 4'd13,
    MOP_IOTA     = 4'd14,
    MOP_INDEX    = 4'd15
  } mop_e;

  // Mirrors the bit layout of the instruction word, MSB first.
  typedef struct packed {
    logic [5:0]       sel;
    logic             vm;
    logic [IDX_W-1:0] s2;
    logic [IDX_W-1:0] s1;
    logic [2:0]       minor;
    logic [IDX_W-1:0] dst;
    logic [6:0]       major;
  } ifields_t;

  typedef struct packed {
    logic             legal;
    mop_e             op;
    logic             scalar_dst;
    logic [IDX_W-1:0] dst;
    logic [IDX_W-1:0] src2;
    logic [IDX_W-1:0] src1;
    logic             vm;
  } dec_t;
endpackage

// File: rtl/vmdec_fields.sv
module vmdec_fields
  import vmdec_pkg::*;
(
  input  logic [ILEN-1:0] word,
  output ifields_t        flds,
  output logic            cand
);
  assign flds = ifields_t'(word);
  assign cand = (flds.major == MAJOR_VEC) && (flds.minor == F3_MASKVV);
endmodule

// File: rtl/vmdec_core.sv
module vmdec_core
  import vmdec_pkg::*;
(
  input  ifields_t flds,
  input  logic     cand,
  output dec_t     dec
);
  mop_e op_raw;
  logic ok;

  always_comb begin
    op_raw = MOP_NONE;
    ok     = 1'b0;
    if (cand) begin
      if (flds.sel[5:3] == SEL_LOGIC_HI) begin
        if (flds.vm) begin
          ok     = 1'b1;
          op_raw = mop_e'({1'b0, flds.sel[2:0]} + 4'd1);
        end
      end else if (flds.sel == SEL_SCALAR) begin
        case (flds.s1)
          5'b10000: begin ok = 1'b1; op_raw = MOP_POPCNT; end
          5'b10001: begin ok = 1'b1; op_raw = MOP_FIRST;  end
          default:  begin ok = 1'b0; op_raw = MOP_NONE;   end
        endcase
      end else if (flds.sel == SEL_UNARY) begin
        case (flds.s1)
          5'b00001: begin ok = 1'b1; op_raw = MOP_SETBEF;  end
          5'b00010: begin ok = 1'b1; op_raw = MOP_SETONLY; end
          5'b00011: begin ok = 1'b1; op_raw = MOP_SETINCL; end
          5'b10000: begin ok = 1'b1; op_raw = MOP_IOTA;    end
          5'b10001: begin ok = (flds.s2 == '0); op_raw = MOP_INDEX; end
          default:  begin ok = 1'b0; op_raw = MOP_NONE;    end
        endcase
      end
    end
  end

  always_comb begin
    dec.legal      = ok;
    dec.op         = ok ? op_raw : MOP_NONE;
    dec.scalar_dst = ok && (op_raw == MOP_POPCNT || op_raw == MOP_FIRST);
    dec.dst        = flds.dst;
    dec.src2       = flds.s2;
    dec.src1       = flds.s1;
    dec.vm         = flds.vm;
  end
endmodule

// File: rtl/vmdec_stage.sv
module vmdec_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign up_ready = !full_q || dn_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
    end else if (up_valid && up_ready) begin
      full_q <= 1'b1;
    end else if (dn_ready) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (up_valid && up_ready) data_q <= up_data;
  end

  assign dn_valid = full_q;
  assign dn_data  = data_q;
endmodule

// File: rtl/vmask_decoder.sv
module vmask_decoder
  import vmdec_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ILEN-1:0]  in_word,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_legal,
  output logic [OP_W-1:0]  out_op,
  output logic             out_scalar_dst,
  output logic [IDX_W-1:0] out_dst,
  output logic [IDX_W-1:0] out_src2,
  output logic [IDX_W-1:0] out_src1,
  output logic             out_vm
);
  localparam int DW = $bits(dec_t);

  ifields_t flds;
  logic     cand;
  dec_t     dec_c;
  dec_t     dec_q;
  logic [DW-1:0] q_bits;

  vmdec_fields u_fields (.word(in_word), .flds(flds), .cand(cand));
  vmdec_core   u_core   (.flds(flds), .cand(cand), .dec(dec_c));

  vmdec_stage #(.W(DW)) u_stage (
    .clk(clk), .rst(rst),
    .up_valid(in_valid), .up_ready(in_ready), .up_data(dec_c),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(q_bits)
  );

  assign dec_q          = dec_t'(q_bits);
  assign out_legal      = dec_q.legal;
  assign out_op         = dec_q.op;
  assign out_scalar_dst = dec_q.scalar_dst;
  assign out_dst        = dec_q.dst;
  assign out_src2       = dec_q.src2;
  assign out_src1       = dec_q.src1;
  assign out_vm         = dec_q.vm;
endmodule

// File: rtl/vmask_decoder_chk.sv
module vmask_decoder_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_legal,
  input logic [3:0] out_op,
  input logic       out_scalar_dst,
  input logic [4:0] out_dst,
  input logic [4:0] out_src2,
  input logic [4:0] out_src1,
  input logic       out_vm
);
  AST_READY_RULE: assert property (@(posedge clk) disable iff (rst)
    in_ready == (!out_valid || out_ready)); // R9
  AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_op) && $stable(out_legal)
      && $stable(out_dst) && $stable(out_src1) && $stable(out_src2) && $stable(out_vm))); // R9
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid); // R10
  AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && out_ready) |=> !out_valid); // R10
  AST_NONE_IF_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_legal) |-> (out_op == 4'd0 && !out_scalar_dst)); // R8
  AST_LOGIC_NEEDS_VM: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_legal && out_op >= 4'd1 && out_op <= 4'd8) |-> out_vm); // R3
  AST_SCALAR_ONLY_POP_FIRST: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_scalar_dst) |-> (out_op == 4'd9 || out_op == 4'd10)); // R4
  AST_INDEX_SRC2_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_legal && out_op == 4'd15) |-> (out_src2 == 5'd0)); // R6
endmodule

bind vmask_decoder vmask_decoder_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_legal(out_legal),
  .out_op(out_op), .out_scalar_dst(out_scalar_dst), .out_dst(out_dst),
  .out_src2(out_src2), .out_src1(out_src1), .out_vm(out_vm)
);

// File: tb/vmask_decoder_test.sv
module vmask_decoder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_legal;
  logic [3:0]  out_op;
  logic        out_scalar_dst;
  logic [4:0]  out_dst, out_src2, out_src1;
  logic        out_vm;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vmask_decoder uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_legal(out_legal), .out_op(out_op), .out_scalar_dst(out_scalar_dst),
    .out_dst(out_dst), .out_src2(out_src2), .out_src1(out_src1), .out_vm(out_vm)
  );

  function automatic logic [31:0] mk(input logic [5:0] sel, input logic vm,
      input logic [4:0] s2, input logic [4:0] s1, input logic [2:0] f3,
      input logic [4:0] d, input logic [6:0] maj);
    return {sel, vm, s2, s1, f3, d, maj};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Send one word with downstream ready; sample after the capturing edge.
  task automatic send(input logic [31:0] w);
    @(negedge clk);
    in_word  = w;
    in_valid = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_dec(input string req, input logic [31:0] w, input int legal,
                            input int op, input int sdst);
    send(w);
    chk(req, "valid", out_valid, 1);
    chk(req, "legal", out_legal, legal);
    chk(req, "op", out_op, op);
    chk(req, "scalar_dst", out_scalar_dst, sdst);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R10", "valid after reset", out_valid, 0);
    chk("R9", "ready after reset", in_ready, 1);
  endtask

  task automatic t_logic;
    for (int k = 0; k < 8; k++) begin
      expect_dec("R3", mk(6'b011000 + 6'(k), 1'b1, 5'd3, 5'd4, 3'b010, 5'd5, 7'b1010111), 1, k + 1, 0);
      expect_dec("R3", mk(6'b011000 + 6'(k), 1'b0, 5'd3, 5'd4, 3'b010, 5'd5, 7'b1010111), 0, 0, 0);
    end
  endtask

  task automatic t_scalar;
    expect_dec("R4", mk(6'b010000, 1'b1, 5'd8, 5'b10000, 3'b010, 5'd12, 7'b1010111), 1, 9, 1);
    expect_dec("R4", mk(6'b010000, 1'b0, 5'd8, 5'b10001, 3'b010, 5'd12, 7'b1010111), 1, 10, 1);
    chk("R4", "vm passthrough", out_vm, 0);
  endtask

  task automatic t_unary;
    expect_dec("R5", mk(6'b010100, 1'b1, 5'd2, 5'b00001, 3'b010, 5'd1, 7'b1010111), 1, 11, 0);
    expect_dec("R5", mk(6'b010100, 1'b0, 5'd2, 5'b00010, 3'b010, 5'd1, 7'b1010111), 1, 12, 0);
    expect_dec("R5", mk(6'b010100, 1'b1, 5'd2, 5'b00011, 3'b010, 5'd1, 7'b1010111), 1, 13, 0);
    expect_dec("R5", mk(6'b010100, 1'b1, 5'd2, 5'b10000, 3'b010, 5'd1, 7'b1010111), 1, 14, 0);
    expect_dec("R5", mk(6'b010100, 1'b1, 5'd0, 5'b10001, 3'b010, 5'd1, 7'b1010111), 1, 15, 0);
  endtask

  task automatic t_index;
    expect_dec("R6", mk(6'b010100, 1'b1, 5'd1, 5'b10001, 3'b010, 5'd1, 7'b1010111), 0, 0, 0);
    expect_dec("R6", mk(6'b010100, 1'b1, 5'd16, 5'b10001, 3'b010, 5'd1, 7'b1010111), 0, 0, 0);
  endtask

  task automatic t_major;
    expect_dec("R1", mk(6'b011001, 1'b1, 5'd1, 5'd2, 3'b010, 5'd3, 7'b1010110), 0, 0, 0);
    expect_dec("R1", mk(6'b011001, 1'b1, 5'd1, 5'd2, 3'b000, 5'd3, 7'b1010111), 0, 0, 0);
    expect_dec("R1", mk(6'b010000, 1'b1, 5'd1, 5'b10000, 3'b110, 5'd3, 7'b1010111), 0, 0, 0);
  endtask

  task automatic t_subcodes;
    expect_dec("R7", mk(6'b010001, 1'b1, 5'd1, 5'b10000, 3'b010, 5'd3, 7'b1010111), 0, 0, 0);
    expect_dec("R7", mk(6'b010111, 1'b1, 5'd1, 5'b00001, 3'b010, 5'd3, 7'b1010111), 0, 0, 0);
    expect_dec("R7", mk(6'b010000, 1'b1, 5'd1, 5'b00001, 3'b010, 5'd3, 7'b1010111), 0, 0, 0);
    expect_dec("R7", mk(6'b010100, 1'b1, 5'd1, 5'b00000, 3'b010, 5'd3, 7'b1010111), 0, 0, 0);
    expect_dec("R7", mk(6'b010100, 1'b1, 5'd1, 5'b10010, 3'b010, 5'd3, 7'b1010111), 0, 0, 0);
    expect_dec("R8", mk(6'b010000, 1'b1, 5'd1, 5'b11111, 3'b010, 5'd3, 7'b1010111), 0, 0, 0);
  endtask

  task automatic t_fields;
    send(mk(6'b011010, 1'b1, 5'd21, 5'd10, 3'b010, 5'd30, 7'b1010111));
    chk("R2", "dst", out_dst, 30);
    chk("R2", "src1", out_src1, 10);
    chk("R2", "src2", out_src2, 21);
    chk("R2", "vm", out_vm, 1);
    chk("R2", "op", out_op, 3);
  endtask

  task automatic t_handshake;
    logic [31:0] wa, wb;
    wa = mk(6'b011011, 1'b1, 5'd1, 5'd2, 3'b010, 5'd7, 7'b1010111);
    wb = mk(6'b010100, 1'b1, 5'd0, 5'b10000, 3'b010, 5'd9, 7'b1010111);
    @(negedge clk);
    out_ready = 1'b0;
    in_word = wa; in_valid = 1'b1;
    @(negedge clk);
    in_word = wb;
    chk("R10", "A captured valid", out_valid, 1);
    chk("R10", "A op", out_op, 4);
    chk("R9", "ready low when full and stalled", in_ready, 0);
    repeat (3) begin
      @(negedge clk);
      chk("R9", "A held op", out_op, 4);
      chk("R9", "A held dst", out_dst, 7);
    end
    out_ready = 1'b1;
    #1;
    chk("R9", "ready follows out_ready", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10", "B valid", out_valid, 1);
    chk("R10", "B op", out_op, 14);
    chk("R10", "B dst", out_dst, 9);
    @(negedge clk);
    chk("R10", "drained", out_valid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_logic();
    t_scalar();
    t_unary();
    t_index();
    t_major();
    t_subcodes();
    t_fields();
    t_handshake();
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule